// File: doc/BRIEF.md
# Compare Flags and Branch Resolver

This block holds the outcome of the most recent integer comparison in a small five-bit condition register. Another cycle can then ask whether a conditional branch is taken. On a compare strobe, two 32-bit operands are compared. Equality and the signed and unsigned orderings are recorded as separate bits. A later branch strobe carries a 4-bit condition selector, a 10-bit displacement counted in halfwords, and the address of the branch instruction. The block tests the selected condition against the stored flags and drives the address of the next instruction.

Branch resolution is combinational from the branch inputs and the registered flags. A compare and a branch issued in the same cycle therefore see the flags stored before that cycle. The new comparison becomes visible one clock later. A selector outside the ten defined conditions is reported on an illegal-instruction output and never redirects the flow.

Top module: `cmpbr_resolver`

## Requirements
- R1: After a synchronous active-high reset, the flag output reads 5'b00000.
- R2: The flag register loads only in a cycle with the compare strobe high. It holds its value in every other cycle. A loaded value appears on the flag output after the next rising clock edge.
- R3: When the two operands are equal, the stored flags are exactly 5'b00100: bit 2 (equal) is set and every ordering bit is clear.
- R4: When the operands differ, the signed ordering sets bit 1 (less) or bit 0 (greater). The unsigned ordering independently sets bit 4 (less) or bit 3 (greater). For operands that differ in sign, the two orderings can disagree.
- R5: With the branch strobe high, the taken output follows the selector:
  - 0: bit 2.
  - 1: not bit 2.
  - 2: bit 1.
  - 3: bit 0.
  - 4: bit 4.
  - 5: bit 3.
  - 6: bit 0 or bit 2.
  - 7: bit 1 or bit 2.
  - 8: bit 3 or bit 2.
  - 9: bit 4 or bit 2.
- R6: For a taken branch, the next address is the instruction address plus the displacement, sign-extended from 10 bits and multiplied by two, modulo 2^32.
- R7: For a branch that is not taken, and in any cycle without the branch strobe, the next address is the instruction address plus 2, and taken is low.
- R8: A selector of 10 to 15 with the branch strobe high raises the illegal output, keeps taken low and gives the address plus 2. Without the strobe, illegal stays low.
- R9: A branch issued in the same cycle as a compare is resolved against the flags stored before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmp_en_i | input | 1 | Compare strobe |
| opa_i | input | 32 | First compare operand |
| opb_i | input | 32 | Second compare operand |
| br_en_i | input | 1 | Branch strobe |
| br_cond_i | input | 4 | Condition selector |
| br_disp_i | input | 10 | Signed displacement in halfwords |
| pc_i | input | 32 | Address of the branch instruction |
| flags_o | output | 5 | Stored flags: bit0 greater, bit1 less, bit2 equal, bit3 unsigned greater, bit4 unsigned less |
| taken_o | output | 1 | Branch taken |
| illegal_o | output | 1 | Undefined condition selector |
| next_pc_o | output | 32 | Address of the next instruction |

## Verification
The bench uses the default parameters: 32-bit operands and addresses, and a 10-bit displacement. With these values, the operand pairs that differ only in the top bit make the signed and unsigned flag bits disagree. The displacement extremes 0x1FF and 0x200 reach the largest forward and backward jumps. Every selector from 0 to 15 is applied after each directed and random comparison, which covers all ten conditions and the six illegal codes. Cycles that raise both strobes at once show whether the branch sees the old flags.

// File: rtl/cmpbr_pkg.sv
package cmpbr_pkg;

    localparam int FLAG_W = 5;
    localparam int COND_W = 4;

    // Field order matches the bit positions that branch conditions decode.
    typedef struct packed {
        logic ult;   // bit 4
        logic ugt;   // bit 3
        logic eq;    // bit 2
        logic slt;   // bit 1
        logic sgt;   // bit 0
    } flags_t;

    typedef enum logic [COND_W-1:0] {
        C_EQ  = 4'd0,
        C_NE  = 4'd1,
        C_SLT = 4'd2,
        C_SGT = 4'd3,
        C_ULT = 4'd4,
        C_UGT = 4'd5,
        C_SGE = 4'd6,
        C_SLE = 4'd7,
        C_UGE = 4'd8,
        C_ULE = 4'd9
    } cond_e;

    localparam logic [COND_W-1:0] COND_LAST = 4'd9;

    function automatic logic cond_legal(input logic [COND_W-1:0] sel);
        return sel <= COND_LAST;
    endfunction

    function automatic logic cond_hit(input flags_t f, input logic [COND_W-1:0] sel);
        logic hit;
        case (cond_e'(sel))
            C_EQ:    hit = f.eq;
            C_NE:    hit = !f.eq;
            C_SLT:   hit = f.slt;
            C_SGT:   hit = f.sgt;
            C_ULT:   hit = f.ult;
            C_UGT:   hit = f.ugt;
            C_SGE:   hit = f.sgt | f.eq;
            C_SLE:   hit = f.slt | f.eq;
            C_UGE:   hit = f.ugt | f.eq;
            C_ULE:   hit = f.ult | f.eq;
            default: hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
    import cmpbr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output flags_t            flags_q
);

    flags_t next_flags;

    always_comb begin
        next_flags     = '0;
        next_flags.eq  = (a == b);
        if (!next_flags.eq) begin
            next_flags.slt = $signed(a) < $signed(b);
            next_flags.sgt = $signed(a) > $signed(b);
            next_flags.ult = a < b;
            next_flags.ugt = a > b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else if (load)
            flags_q <= next_flags;
    end

endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
    import cmpbr_pkg::*;
(
    input  logic              en,
    input  logic [COND_W-1:0] sel,
    input  flags_t            flags,
    output logic              taken,
    output logic              illegal
);

    logic legal;

    always_comb begin
        legal   = cond_legal(sel);
        illegal = en && !legal;
        taken   = en && legal && cond_hit(flags, sel);
    end

endmodule

// File: rtl/branch_target_calc.sv
module branch_target_calc #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 10
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [DISP_W-1:0] disp,
    input  logic              taken,
    output logic [ADDR_W-1:0] next_pc
);

    localparam int EXT_W = ADDR_W - DISP_W - 1;
    localparam logic [ADDR_W-1:0] SEQ_STEP = ADDR_W'(2);

    logic [ADDR_W-1:0] byte_off;

    always_comb begin
        byte_off = {{EXT_W{disp[DISP_W-1]}}, disp, 1'b0};
        next_pc  = pc + (taken ? byte_off : SEQ_STEP);
    end

endmodule

// File: rtl/cmpbr_resolver.sv
module cmpbr_resolver
    import cmpbr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int DISP_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_en_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              br_en_i,
    input  logic [COND_W-1:0] br_cond_i,
    input  logic [DISP_W-1:0] br_disp_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic              taken_o,
    output logic              illegal_o,
    output logic [ADDR_W-1:0] next_pc_o
);

    flags_t flags_q;
    logic   taken;

    cmp_flag_unit #(.DATA_W(DATA_W)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .load    (cmp_en_i),
        .a       (opa_i),
        .b       (opb_i),
        .flags_q (flags_q)
    );

    branch_cond_eval u_cond (
        .en      (br_en_i),
        .sel     (br_cond_i),
        .flags   (flags_q),
        .taken   (taken),
        .illegal (illegal_o)
    );

    branch_target_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
        .pc      (pc_i),
        .disp    (br_disp_i),
        .taken   (taken),
        .next_pc (next_pc_o)
    );

    assign flags_o = flags_q;
    assign taken_o = taken;

endmodule

// File: rtl/cmpbr_resolver_chk.sv
module cmpbr_resolver_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cmp_en_i,
    input logic              br_en_i,
    input logic [3:0]        br_cond_i,
    input logic [ADDR_W-1:0] pc_i,
    input logic [4:0]        flags_o,
    input logic              taken_o,
    input logic              illegal_o,
    input logic [ADDR_W-1:0] next_pc_o
);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> flags_o == 5'd0); // R1
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cmp_en_i |=> $stable(flags_o)); // R2
    AST_EQ_ALONE: assert property (@(posedge clk) disable iff (rst)
        flags_o[2] |-> flags_o == 5'b00100); // R3
    AST_ORDER_PAIRS: assert property (@(posedge clk) disable iff (rst)
        (flags_o != 5'd0 && !flags_o[2]) |->
            ($countones(flags_o[1:0]) == 1 && $countones(flags_o[4:3]) == 1)); // R4
    AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (rst)
        !taken_o |-> next_pc_o == pc_i + ADDR_W'(2)); // R7
    AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        !br_en_i |-> (!taken_o && !illegal_o)); // R7
    AST_ILLEGAL_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        (br_en_i && br_cond_i >= 4'd10) |-> (illegal_o && !taken_o)); // R8

endmodule

bind cmpbr_resolver cmpbr_resolver_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmp_en_i  (cmp_en_i),
    .br_en_i   (br_en_i),
    .br_cond_i (br_cond_i),
    .pc_i      (pc_i),
    .flags_o   (flags_o),
    .taken_o   (taken_o),
    .illegal_o (illegal_o),
    .next_pc_o (next_pc_o)
);

// File: tb/cmpbr_resolver_test.sv
module cmpbr_resolver_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmp_en_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        br_en_i = 1'b0;
    logic [3:0]  br_cond_i = '0;
    logic [9:0]  br_disp_i = '0;
    logic [31:0] pc_i = '0;
    logic [4:0]  flags_o;
    logic        taken_o;
    logic        illegal_o;
    logic [31:0] next_pc_o;

    int checks = 0;
    int failures = 0;
    logic [4:0] mflags = '0;

    always #2 clk = ~clk;

    cmpbr_resolver uut (
        .clk(clk), .rst(rst), .cmp_en_i(cmp_en_i), .opa_i(opa_i), .opb_i(opb_i),
        .br_en_i(br_en_i), .br_cond_i(br_cond_i), .br_disp_i(br_disp_i), .pc_i(pc_i),
        .flags_o(flags_o), .taken_o(taken_o), .illegal_o(illegal_o), .next_pc_o(next_pc_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] ref_flags(input logic [31:0] a, input logic [31:0] b);
        logic [4:0] f = '0;
        if (a == b) return 5'b00100;
        if ($signed(a) < $signed(b)) f |= 5'b00010; else f |= 5'b00001;
        if (a < b) f |= 5'b10000; else f |= 5'b01000;
        return f;
    endfunction

    function automatic logic ref_cond(input logic [4:0] f, input int code);
        case (code)
            0: return f[2];
            1: return !f[2];
            2: return f[1];
            3: return f[0];
            4: return f[4];
            5: return f[3];
            6: return f[0] | f[2];
            7: return f[1] | f[2];
            8: return f[3] | f[2];
            9: return f[4] | f[2];
            default: return 1'b0;
        endcase
    endfunction

    task automatic step(input bit c, input logic [31:0] a, input logic [31:0] b,
                        input bit bs, input int code, input logic [9:0] d,
                        input logic [31:0] pc);
        logic exp_take;
        logic exp_ill;
        logic [31:0] exp_pc;
        int off;
        @(negedge clk);
        cmp_en_i = c; opa_i = a; opb_i = b;
        br_en_i = bs; br_cond_i = 4'(code); br_disp_i = d; pc_i = pc;
        #1;
        exp_ill  = bs && code >= 10;
        exp_take = bs && code < 10 && ref_cond(mflags, code);
        off = int'(d);
        if (off >= 512) off -= 1024;
        exp_pc = exp_take ? pc + 32'(off * 2) : pc + 32'd2;
        chk("R2 flags held", {27'd0, flags_o}, {27'd0, mflags});
        if (c && bs)
            chk("R9 taken uses old flags", {31'd0, taken_o}, {31'd0, exp_take});
        else
            chk("R5 taken", {31'd0, taken_o}, {31'd0, exp_take});
        chk("R8 illegal", {31'd0, illegal_o}, {31'd0, exp_ill});
        if (exp_take) chk("R6 target", next_pc_o, exp_pc);
        else          chk("R7 fall-through", next_pc_o, exp_pc);
        @(posedge clk);
        if (c) begin
            mflags = ref_flags(a, b);
            #1;
            if (a == b) chk("R3 equal flags", {27'd0, flags_o}, {27'd0, mflags});
            else        chk("R4 order flags", {27'd0, flags_o}, {27'd0, mflags});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] pa [8] = '{32'd5, 32'h8000_0000, 32'd1, 32'd3,
                                32'hFFFF_FFFF, 32'd0, 32'hFFFF_FFFF, 32'd0};
        logic [31:0] pb [8] = '{32'd5, 32'd1, 32'h8000_0000, 32'd7,
                                32'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'd0};
        logic [9:0] dsp [4] = '{10'h1FF, 10'h200, 10'h3FF, 10'h001};
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset flags", {27'd0, flags_o}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        // Idle: no strobes, flags stay zero, sequential address (R2, R7).
        step(0, 32'h1234, 32'h99, 0, 3, 10'h1FF, 32'h100);
        // Sign-differing pair: signed less, unsigned greater (R4) -> 5'b01010.
        step(1, 32'h8000_0000, 32'd1, 0, 0, 10'd0, 32'h200);
        chk("R4 sign split", {27'd0, flags_o}, 32'h0A);
        for (int p = 0; p < 8; p++) begin
            step(1, pa[p], pb[p], 0, 0, 10'd0, 32'h0);
            for (int code = 0; code < 16; code++)
                step(0, $urandom, $urandom, 1, code, dsp[code % 4],
                     32'h0001_0000 + 32'(code * 4));
            // Operands change with no strobe: flags must hold (R2).
            step(0, $urandom, $urandom, 0, 0, 10'd0, 32'h40);
        end
        // Same-cycle compare and branch (R9).
        step(1, 32'd9, 32'd9, 0, 0, 10'd0, 32'h0);
        step(1, 32'd1, 32'd2, 1, 0, 10'h010, 32'h500);
        step(1, 32'd4, 32'd4, 1, 2, 10'h010, 32'h600);
        step(0, 0, 0, 1, 0, 10'h010, 32'h700);
        // Wraparound of the address (R6, R7).
        step(0, 0, 0, 1, 0, 10'h002, 32'hFFFF_FFFE);
        step(0, 0, 0, 1, 1, 10'h002, 32'hFFFF_FFFE);
        // Random compares and branches.
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra = $urandom;
            logic [31:0] rb = (i % 5 == 0) ? ra : $urandom;
            step(($urandom % 2) == 1, ra, rb, ($urandom % 2) == 1,
                 int'($urandom % 16), 10'($urandom), $urandom & 32'hFFFF_FFFE);
        end
        // Reset in mid-run clears the flags (R1).
        step(1, 32'd1, 32'd0, 0, 0, 10'd0, 32'h0);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 reset mid-run", {27'd0, flags_o}, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule